// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Array

This block holds a 2048-byte bank of counters that many requesters update without locks. Each request arrives on a single valid/ready port and performs one indivisible read-modify-write on one counter. The counter can be 1, 2, 4 or 8 bytes wide. A load request carries its whole operation in the address: the counter's byte offset, a signed 22-bit increment and a wait flag. It returns the counter's value from before the update and leaves the sum behind. A store request carries its operand on the data lines. An address flag chooses whether that operand is added to the counter or written over it. A store returns nothing.

A load with the wait flag set is parked in a side slot until an external "tag switch finished" input is seen. Only then is its add performed. If that input does not arrive within a parameterised number of cycles, the request completes with an error flag in bit 63 and the counter is left alone. While a request is parked, the port keeps serving requests to other 8-byte words. Requests that touch the parked word are held off, so requests to the same word stay in arrival order.

Top module: `fadd_array`

## Requirements
- R1: After reset every counter byte reads zero, `rsp_valid` is low and `req_ready` is high.
- R2: A load with address bit 13 clear is answered in the cycle after acceptance. `rsp_waited` is 0 and `rsp_data` is the counter's pre-update value sign-extended to 64 bits. The counter becomes its old value plus the increment. The increment is address bits 35:14 sign-extended, and the sum wraps at the access width.
- R3: `req_size` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Counters are big-endian within their aligned 8-byte word: byte offset 0 is the word's most significant byte. An access changes only the bytes of its own counter.
- R4: Offset bits below the access alignment (bit 0 for 2 bytes, bits 1:0 for 4 bytes, bits 2:0 for 8 bytes) are ignored.
- R5: A store with address bit 13 clear adds the low bits of `req_wdata`, with wrap at the access width. With bit 13 set, it replaces the counter with those bits. A store never produces a response.
- R6: A load with address bit 13 set performs its add in the first cycle after acceptance in which `tag_done` is high. It responds one cycle later with `rsp_waited`=1, bit 63 = 0 and bits 62:0 holding the sign-extended pre-update value.
- R7: If `tag_done` stays low for TIMEOUT cycles after a waiting load is accepted, the load responds with `rsp_waited`=1 and bit 63 = 1, and the counter is unchanged. A `tag_done` in the last of those cycles still performs the add.
- R8: While a load is parked, requests to other 8-byte words are accepted and completed. Requests to the parked word, and any second waiting load, see `req_ready` low.
- R9: In the cycle a parked load completes or times out, `req_ready` is low, so its update and response take precedence over the port.
- R10: Requests accepted on consecutive cycles to the same counter each see the previous request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_load | input | 1 | 1 = fetch-and-add load, 0 = store |
| req_addr | input | ADDR_W (36) | Bits 10:0 byte offset, bit 13 wait/overwrite flag, bits 35:14 load increment |
| req_size | input | 2 | Access width code (R3) |
| req_wdata | input | 64 | Store operand, low bits used |
| tag_done | input | 1 | Tag switch finished, releases a parked load |
| rsp_valid | output | 1 | Load response present for one cycle |
| rsp_waited | output | 1 | Response belongs to the parked waiting load |
| rsp_data | output | 64 | Pre-update value; bit 63 is the error flag on waited responses |

## Verification
The parked load's release, or its timeout, can land in the same cycle as a new request on the port. The hazard is most acute when that new request targets the parked word or is itself a waiting load. The bench schedules `tag_done` for the exact cycle in which such a request is being offered. It also schedules it for the final cycle of the timeout window. A cycle-level model then judges who owns that cycle: it predicts `req_ready` each clock, predicts which operation updates the counter, and predicts the response that follows, including whether the error flag is set. Every response and every later read-back of the counter bytes is compared against that model.

// File: rtl/fadd_pkg.sv
// Shared types for the fetch-and-add counter array.
// Assumes 64-bit storage words holding eight big-endian byte lanes.
package fadd_pkg;
    localparam int WORD_W     = 64;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } fadd_size_e;
endpackage

// File: rtl/fadd_lane_alu.sv
// Extracts one counter from a 64-bit storage word and computes the updated word.
// Assumes big-endian lanes: byte offset 0 is bits 63:56. Offset bits below the
// access alignment are dropped. The sum wraps at the access width.
module fadd_lane_alu
    import fadd_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] offset,
    input  fadd_size_e        size,
    input  logic [WORD_W-1:0] operand,
    input  logic              overwrite,
    output logic [WORD_W-1:0] old_val,
    output logic [WORD_W-1:0] word_out
);
    logic [LANE_W-1:0] al_off;
    logic [3:0]        nbytes;
    logic [6:0]        shamt;
    logic [WORD_W-1:0] mask, lane, opnd, sum_lane;

    // Lane position and width for the selected access size
    always_comb begin
        nbytes = 4'd1 << size;
        unique case (size)
            SZ_BYTE: begin al_off = offset;                mask = 64'h0000_0000_0000_00FF; end
            SZ_HALF: begin al_off = {offset[2:1], 1'b0};   mask = 64'h0000_0000_0000_FFFF; end
            SZ_WORD: begin al_off = {offset[2], 2'b00};    mask = 64'h0000_0000_FFFF_FFFF; end
            default: begin al_off = 3'd0;                  mask = '1;                      end
        endcase
        shamt = (7'd8 - 7'(al_off) - 7'(nbytes)) << 3;
    end

    // Old value, sign-extended, and the merged result word
    always_comb begin
        lane     = (word_in >> shamt) & mask;
        opnd     = operand & mask;
        sum_lane = overwrite ? opnd : ((lane + opnd) & mask);
        word_out = (word_in & ~(mask << shamt)) | (sum_lane << shamt);
        unique case (size)
            SZ_BYTE: old_val = {{56{lane[7]}},  lane[7:0]};
            SZ_HALF: old_val = {{48{lane[15]}}, lane[15:0]};
            SZ_WORD: old_val = {{32{lane[31]}}, lane[31:0]};
            default: old_val = lane;
        endcase
    end
endmodule

// File: rtl/fadd_wait_slot.sv
// Holds one parked waiting load until tag_done or until TIMEOUT cycles pass.
// Assumes capture is only asserted while the slot is empty.
module fadd_wait_slot
    import fadd_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int TIMEOUT = 1024,
    localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [LANE_W-1:0] cap_off,
    input  fadd_size_e        cap_size,
    input  logic [WORD_W-1:0] cap_inc,
    input  logic              tag_done,
    output logic              busy,
    output logic              fire,
    output logic              tmo,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] off,
    output fadd_size_e        size,
    output logic [WORD_W-1:0] inc
);
    logic [CNT_W-1:0] age;

    assign fire = busy & tag_done;
    assign tmo  = busy & ~tag_done & (age == CNT_W'(TIMEOUT - 1));

    // Occupancy and age of the parked request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            age  <= '0;
        end else if (capture) begin
            busy <= 1'b1;
            age  <= '0;
        end else if (fire || tmo) begin
            busy <= 1'b0;
        end else if (busy) begin
            age <= age + 1'b1;
        end
    end

    // Parked request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            off  <= '0;
            size <= SZ_BYTE;
            inc  <= '0;
        end else if (capture) begin
            idx  <= cap_idx;
            off  <= cap_off;
            size <= cap_size;
            inc  <= cap_inc;
        end
    end
endmodule

// File: rtl/fadd_array.sv
// Array of atomic counters reached over one valid/ready request port.
// Loads fetch-and-add with an increment taken from the address. Stores add or
// overwrite. Loads flagged to wait are parked until tag_done or a timeout.
// Assumes one request is offered at a time and responses are always taken.
module fadd_array
    import fadd_pkg::*;
#(
    parameter int SPACE_BYTES = 2048,
    parameter int ADDR_W      = 36,
    parameter int FLAG_BIT    = 13,
    parameter int INC_LSB     = 14,
    parameter int INC_W       = 22,
    parameter int TIMEOUT     = 1024,
    localparam int OFF_W      = $clog2(SPACE_BYTES),
    localparam int WORDS      = SPACE_BYTES / WORD_BYTES,
    localparam int IDX_W      = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              tag_done,
    output logic              rsp_valid,
    output logic              rsp_waited,
    output logic [WORD_W-1:0] rsp_data
);
    logic [WORD_W-1:0] mem [WORDS];

    logic [IDX_W-1:0]  req_idx;
    logic [LANE_W-1:0] req_off;
    logic              req_flag, wait_req, accept;
    logic [INC_W-1:0]  inc_field;
    logic [WORD_W-1:0] req_inc;

    logic              slot_busy, slot_fire, slot_tmo;
    logic [IDX_W-1:0]  slot_idx;
    logic [LANE_W-1:0] slot_off;
    fadd_size_e        slot_size;
    logic [WORD_W-1:0] slot_inc;

    logic [IDX_W-1:0]  alu_idx;
    logic [LANE_W-1:0] alu_off;
    fadd_size_e        alu_size;
    logic [WORD_W-1:0] alu_opnd, alu_old, alu_new;
    logic              alu_ovr;

    // Request field decode
    assign req_idx   = req_addr[OFF_W-1:LANE_W];
    assign req_off   = req_addr[LANE_W-1:0];
    assign req_flag  = req_addr[FLAG_BIT];
    assign inc_field = req_addr[INC_LSB +: INC_W];
    assign req_inc   = {{(WORD_W-INC_W){inc_field[INC_W-1]}}, inc_field};
    assign wait_req  = req_load & req_flag;

    // Port admission: parked completion wins, same word and second waiter stall
    assign req_ready = ~(slot_fire | slot_tmo)
                     & ~(slot_busy & (req_idx == slot_idx))
                     & ~(wait_req & slot_busy);
    assign accept    = req_valid & req_ready;

    fadd_wait_slot #(.IDX_W(IDX_W), .TIMEOUT(TIMEOUT)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept & wait_req),
        .cap_idx  (req_idx),
        .cap_off  (req_off),
        .cap_size (fadd_size_e'(req_size)),
        .cap_inc  (req_inc),
        .tag_done (tag_done),
        .busy     (slot_busy),
        .fire     (slot_fire),
        .tmo      (slot_tmo),
        .idx      (slot_idx),
        .off      (slot_off),
        .size     (slot_size),
        .inc      (slot_inc)
    );

    // Select the operation that owns the shared lane adder this cycle
    always_comb begin
        if (slot_fire) begin
            alu_idx  = slot_idx;
            alu_off  = slot_off;
            alu_size = slot_size;
            alu_opnd = slot_inc;
            alu_ovr  = 1'b0;
        end else begin
            alu_idx  = req_idx;
            alu_off  = req_off;
            alu_size = fadd_size_e'(req_size);
            alu_opnd = req_load ? req_inc : req_wdata;
            alu_ovr  = ~req_load & req_flag;
        end
    end

    fadd_lane_alu u_alu (
        .word_in   (mem[alu_idx]),
        .offset    (alu_off),
        .size      (alu_size),
        .operand   (alu_opnd),
        .overwrite (alu_ovr),
        .old_val   (alu_old),
        .word_out  (alu_new)
    );

    // Counter storage write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (slot_fire || (accept && !wait_req)) begin
            mem[alu_idx] <= alu_new;
        end
    end

    // Response register: parked completion or immediate load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_waited <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid  <= slot_fire | slot_tmo | (accept & req_load & ~req_flag);
            rsp_waited <= slot_fire | slot_tmo;
            if (slot_tmo)       rsp_data <= {1'b1, {(WORD_W-1){1'b0}}};
            else if (slot_fire) rsp_data <= {1'b0, alu_old[WORD_W-2:0]};
            else                rsp_data <= alu_old;
        end
    end
endmodule

// File: rtl/fadd_array_chk.sv
// Temporal checks on the counter array's port and parked-load slot.
// Assumes it is attached by the bind below.
module fadd_array_chk #(
    parameter int ADDR_W   = 36,
    parameter int OFF_W    = 11,
    parameter int IDX_W    = 8,
    parameter int FLAG_BIT = 13,
    parameter int TIMEOUT  = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_load,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_waited,
    input logic [63:0]       rsp_data,
    input logic              busy,
    input logic              fire,
    input logic              tmo,
    input logic [IDX_W-1:0]  slot_idx
);
    localparam int CW = $clog2(TIMEOUT + 1) + 1;
    logic [CW-1:0] wait_cnt;
    logic          acc;

    assign acc = req_valid & req_ready;

    // Cycles the slot has been occupied so far
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) wait_cnt <= '0;
        else                 wait_cnt <= wait_cnt + 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rsp_valid && req_ready));
    a_r2_load_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_load && !req_addr[FLAG_BIT]) |=> (rsp_valid && !rsp_waited));
    a_r5_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_load) |=> !rsp_valid);
    a_r6_slot_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (fire || tmo) |=> (rsp_valid && rsp_waited));
    a_r6_waited_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_waited) |-> $past(fire || tmo));
    a_r6_no_error_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !rsp_data[63]);
    a_r7_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> rsp_data[63]);
    a_r7_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wait_cnt < CW'(TIMEOUT)));
    a_r7_fire_tmo_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire, tmo}));
    a_r8_same_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (req_addr[OFF_W-1:3] == slot_idx)) |-> !req_ready);
    a_r8_one_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_load && req_addr[FLAG_BIT]) |-> !req_ready);
    a_r9_completion_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fire || tmo) |-> !req_ready);
endmodule

bind fadd_array fadd_array_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .FLAG_BIT(FLAG_BIT), .TIMEOUT(TIMEOUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_load(req_load), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_waited(rsp_waited), .rsp_data(rsp_data), .busy(slot_busy),
    .fire(slot_fire), .tmo(slot_tmo), .slot_idx(slot_idx)
);

// File: tb/fadd_array_bench.sv
// Bench: byte-level behavioural model stepped and compared every clock.
module fadd_array_bench;
    localparam int TMO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_load = 1'b0;
    logic [35:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        tag_done = 1'b0;
    logic        rsp_valid, rsp_waited;
    logic [63:0] rsp_data;

    always #5 clk = ~clk;

    fadd_array #(.TIMEOUT(TMO)) u_fadd_array (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_load(req_load), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .tag_done(tag_done), .rsp_valid(rsp_valid),
        .rsp_waited(rsp_waited), .rsp_data(rsp_data)
    );

    int    n_chk = 0, n_fail = 0, ncyc = 0, tag_at = -1, wd = 0;
    string ph = "R1";
    bit    accepted;
    logic [7:0] mb [2048];
    bit    m_busy = 0;
    int    m_age, m_a, m_n;
    logic [63:0] m_inc;

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", ph, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(int a, int n);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 64'(mb[a+i]);
        return v;
    endfunction

    function automatic void wr(int a, int n, logic [63:0] v);
        for (int i = 0; i < n; i++) mb[a+n-1-i] = 8'(v >> (8*i));
    endfunction

    function automatic logic [63:0] sx(logic [63:0] v, int n);
        logic [63:0] t = v << (64 - 8*n);
        return $signed(t) >>> (64 - 8*n);
    endfunction

    function automatic logic [35:0] la(bit flag, int inc, int off);
        return (36'(inc & 32'h3F_FFFF) << 14) | (36'(flag) << 13) | 36'(off);
    endfunction

    // One clock: predict ready and response, then compare after the edge
    task automatic cycle();
        int n, a;
        bit complete, eready, nv, nerr;
        logic [63:0] nd, old, inc64;
        ncyc++;
        tag_done = (ncyc == tag_at);
        #1;
        n = 1 << req_size;
        a = int'(req_addr[10:0]) & ~(n - 1);
        complete = m_busy && (tag_done || m_age == TMO - 1);
        eready = !complete && !(m_busy && (a >> 3) == (m_a >> 3))
                 && !(req_load && req_addr[13] && m_busy);
        chk(req_ready === eready, "req_ready", 64'(req_ready), 64'(eready));
        nv = 0; nerr = 0; nd = '0; accepted = 0;
        if (complete) begin
            nv = 1;
            if (tag_done) begin
                old = rd(m_a, m_n);
                wr(m_a, m_n, old + m_inc);
                nd = sx(old, m_n);
                nd[63] = 1'b0;
            end else nerr = 1;
            m_busy = 0;
        end else if (m_busy) m_age++;
        if (req_valid && eready) begin
            accepted = 1;
            inc64 = sx(64'(req_addr[35:14]), 0) ;
            inc64 = {{42{req_addr[35]}}, req_addr[35:14]};
            if (req_load && !req_addr[13]) begin
                old = rd(a, n);
                wr(a, n, old + inc64);
                nv = 1;
                nd = sx(old, n);
            end else if (req_load) begin
                m_busy = 1; m_age = 0; m_a = a; m_n = n; m_inc = inc64;
            end else if (req_addr[13]) wr(a, n, req_wdata);
            else wr(a, n, rd(a, n) + req_wdata);
        end
        @(posedge clk); #1;
        chk(rsp_valid === nv, "rsp_valid", 64'(rsp_valid), 64'(nv));
        if (nv && rsp_valid) begin
            chk(rsp_waited === (nerr || complete), "rsp_waited", 64'(rsp_waited), 64'(complete));
            if (nerr) chk(rsp_data[63] === 1'b1, "error flag", rsp_data, 64'h8000_0000_0000_0000);
            else      chk(rsp_data === nd, "rsp_data", rsp_data, nd);
        end
    endtask

    task automatic issue(bit ld, logic [35:0] ad, logic [1:0] sz, logic [63:0] wdat);
        int tries = 0;
        req_valid = 1; req_load = ld; req_addr = ad; req_size = sz; req_wdata = wdat;
        do begin cycle(); tries++; end while (!accepted && tries < 60);
        req_valid = 0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cycle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) mb[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1: idle port after reset, counters zero
        chk(req_ready === 1'b1, "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0, "no response after reset", 64'(rsp_valid), 64'd0);
        issue(1, la(0, 0, 12'h7F8), 2'd3, '0);
        idle(1);

        ph = "R2";  // immediate fetch-and-add, signed increments
        issue(1, la(0, 5, 8), 2'd3, '0);
        issue(1, la(0, -3, 8), 2'd3, '0);
        issue(1, la(0, 32'h1F_FFFF, 8), 2'd2, '0);
        issue(1, la(0, -1, 12), 2'd2, '0);
        issue(1, la(0, 0, 8), 2'd3, '0);
        idle(1);

        ph = "R3";  // byte and half lanes, big-endian placement, wrap
        issue(1, la(0, 8'h11, 16), 2'd0, '0);
        issue(1, la(0, 8'h22, 23), 2'd0, '0);
        issue(1, la(0, 16'h1234, 18), 2'd1, '0);
        issue(0, la(1, 0, 17), 2'd0, 64'hFF);
        issue(1, la(0, 1, 17), 2'd0, '0);
        issue(1, la(0, 300, 20), 2'd0, '0);
        issue(1, la(0, 0, 16), 2'd3, '0);
        idle(1);

        ph = "R4";  // misaligned low bits dropped
        issue(1, la(0, 9, 16'h21), 2'd2, '0);
        issue(1, la(0, 0, 16'h23), 2'd2, '0);
        issue(1, la(0, 0, 16'h27), 2'd3, '0);
        idle(1);

        ph = "R5";  // overwrite and add stores, no response
        issue(0, la(1, 0, 16'h30), 2'd3, 64'h0123_4567_89AB_CDEF);
        issue(0, la(0, 0, 16'h34), 2'd2, 64'hFFFF_FFFF_0000_0010);
        issue(0, la(0, 0, 16'h31), 2'd0, 64'h1);
        idle(1);
        issue(1, la(0, 0, 16'h30), 2'd3, '0);
        idle(1);

        ph = "R6";  // parked load released by tag_done
        issue(1, la(1, 7, 16'h40), 2'd3, '0);
        tag_at = ncyc + 4;
        ph = "R8";
        issue(1, la(0, 2, 16'h48), 2'd3, '0);
        ph = "R9";  // same-word request offered while release happens
        issue(1, la(0, 1, 16'h44), 2'd2, '0);
        idle(2);

        ph = "R8";  // second waiter held until first completes
        issue(1, la(1, 3, 16'h50), 2'd1, '0);
        tag_at = ncyc + 3;
        issue(1, la(1, 4, 16'h58), 2'd3, '0);
        ph = "R7";  // that second one times out
        idle(TMO + 2);
        issue(1, la(0, 0, 16'h58), 2'd3, '0);
        issue(1, la(1, 6, 16'h60), 2'd2, '0);
        tag_at = ncyc + TMO;  // release in the last allowed cycle
        idle(TMO + 2);
        issue(1, la(0, 0, 16'h60), 2'd3, '0);
        idle(1);

        ph = "R10";  // back-to-back on the same counter
        issue(1, la(0, 1, 16'h70), 2'd1, '0);
        issue(1, la(0, 1, 16'h70), 2'd1, '0);
        issue(0, la(0, 0, 16'h70), 2'd1, 64'h100);
        issue(1, la(0, 0, 16'h70), 2'd1, '0);
        issue(0, la(1, 0, 16'h70), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(1, la(0, 1, 16'h70), 2'd3, '0);
        issue(1, la(0, 0, 16'h70), 2'd3, '0);
        idle(2);
        summary();
    end
endmodule